// File: doc/BRIEF.md
# High-Speed Transmit Edge-Rate Calibration Sequencer

This block runs the one-shot calibration that picks the edge-rate trim of a high-speed serial transmitter. On a start pulse it switches on an on-chip ring oscillator and lets it settle. It then turns on the frequency meter's free-running clock, loads the meter's measurement window and starts the meter. The sequencer checks the meter's valid flag at a fixed poll interval and takes the count when the flag is seen, or anyway once the time limit is used up.

After the meter and its clock are shut down in order, the count is turned into a 3-bit trim code. A serial restoring divider forms the integer quotient of a fixed numerator (window length times reference frequency in MHz times a slope coefficient) by the count. A bank of threshold comparators then rounds that quotient to the nearest thousand and clamps the result to the 3-bit range. A zero count selects a fixed default code. The code is driven onto the trim output while the oscillator is still running. The oscillator is then switched off and a one-cycle done pulse is raised.

All delays are counted in cycles of the reference clock that also clocks the block. They are derived from the reference frequency parameter (default 26 MHz): a 1 µs settle, a 10 µs poll interval and a 200 µs limit.

Top module: `hs_edge_trim_seq`

## Requirements
- R1: When start_i is seen high in idle, osc_en_o and busy_o rise on the next cycle. frck_en_o rises exactly REF_MHZ×SETTLE_US cycles after osc_en_o (26 by default).
- R2: win_cycles_o holds WINDOW (1024) when frck_en_o rises. det_en_o rises one cycle after frck_en_o and is never high while frck_en_o is low.
- R3: While det_en_o is high, meter_valid_i is sampled only once every REF_MHZ×POLL_US cycles (260). At the first sample that finds it high, meter_count_i is captured and det_en_o falls, so det_en_o stays high for a whole multiple of the poll interval.
- R4: If valid has not been seen after LIMIT_US/POLL_US samples (20, that is 5200 cycles), meter_count_i is captured anyway and the sequence continues.
- R5: Shutdown order: det_en_o falls first, frck_en_o falls exactly one cycle later, and osc_en_o falls after that.
- R6: For a nonzero count c, trim_o = min(7, floor((floor(745472 / c) + 500) / 1000)), where 745472 = 1024×26×28. Halves round up.
- R7: A captured count of zero gives trim_o = 4 (DEFAULT_TRIM). Reset also sets trim_o to 4.
- R8: trim_o only changes while osc_en_o is high, and it keeps its value between runs.
- R9: done_o is a one-cycle pulse in the same cycle in which osc_en_o and busy_o fall.
- R10: start_i is ignored while busy_o is high: one run gives exactly one done_o, and no new run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start calibration (single-cycle pulse) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| osc_en_o | output | 1 | Ring oscillator enable |
| frck_en_o | output | 1 | Meter free-running clock enable |
| det_en_o | output | 1 | Meter frequency detector enable |
| win_cycles_o | output | WIN_W | Meter window length in reference cycles |
| meter_valid_i | input | 1 | Meter result valid flag |
| meter_count_i | input | COUNT_W | Meter measured count |
| trim_o | output | TRIM_W | Edge-rate trim code |

## Verification
The hardest paths to reach are a valid flag that arrives between two poll samples and the timeout. A meter that never answers within 200 µs is rare in normal operation. The bench's meter model holds the valid flag low for a programmable number of cycles after the detector is enabled, or keeps it low for good, and then measures the detector-on time. The rounding corners are reached by computing, for each trim step, the count on each side of the half-way point and feeding exactly those counts.

// File: rtl/hs_trim_pkg.sv
package hs_trim_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SETTLE,
    S_ARM,
    S_POLL,
    S_FRCK_OFF,
    S_DIV,
    S_OSC_OFF
  } seq_state_t;
endpackage

// File: rtl/hs_trim_divider.sv
module hs_trim_divider #(
  parameter int NW = 20,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quotient
);
  localparam int CNT_W = $clog2(NW + 1);

  logic [DW-1:0]    rem_q;
  logic [NW-1:0]    quo_q;
  logic [CNT_W-1:0] steps_q;
  logic             run_q;
  logic [DW:0]      trial;

  assign trial    = {rem_q, quo_q[NW-1]};
  assign quotient = quo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      quo_q   <= '0;
      steps_q <= '0;
      run_q   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !run_q) begin
        rem_q   <= '0;
        quo_q   <= dividend;
        steps_q <= CNT_W'(NW);
        run_q   <= 1'b1;
      end else if (run_q) begin
        if (trial >= {1'b0, divisor}) begin
          rem_q <= DW'(trial - {1'b0, divisor});
          quo_q <= {quo_q[NW-2:0], 1'b1};
        end else begin
          rem_q <= trial[DW-1:0];
          quo_q <= {quo_q[NW-2:0], 1'b0};
        end
        steps_q <= steps_q - 1'b1;
        if (steps_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hs_trim_rounder.sv
module hs_trim_rounder #(
  parameter int NW      = 20,
  parameter int DIVISOR = 1000,
  parameter int TRIM_W  = 3
) (
  input  logic [NW-1:0]     quotient,
  output logic [TRIM_W-1:0] code
);
  localparam int MAXC = (1 << TRIM_W) - 1;
  localparam int EW   = NW + 2 + $clog2(DIVISOR * (MAXC + 1));

  logic [EW-1:0]   biased;
  logic [MAXC-1:0] hit;

  assign biased = EW'(quotient) + EW'(DIVISOR / 2);

  for (genvar k = 1; k <= MAXC; k++) begin : g_thr
    assign hit[k-1] = (biased >= EW'(k * DIVISOR));
  end

  assign code = TRIM_W'($countones(hit));
endmodule

// File: rtl/hs_edge_trim_seq.sv
module hs_edge_trim_seq #(
  parameter int REF_MHZ      = 26,
  parameter int WINDOW       = 1024,
  parameter int SETTLE_US    = 1,
  parameter int POLL_US      = 10,
  parameter int LIMIT_US     = 200,
  parameter int SR_COEF      = 28,
  parameter int SR_DIVISOR   = 1000,
  parameter int COUNT_W      = 24,
  parameter int WIN_W        = 24,
  parameter int TRIM_W       = 3,
  parameter int DEFAULT_TRIM = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               osc_en_o,
  output logic               frck_en_o,
  output logic               det_en_o,
  output logic [WIN_W-1:0]   win_cycles_o,
  input  logic               meter_valid_i,
  input  logic [COUNT_W-1:0] meter_count_i,
  output logic [TRIM_W-1:0]  trim_o
);
  import hs_trim_pkg::*;

  localparam int SETTLE_CYC = SETTLE_US * REF_MHZ;
  localparam int POLL_CYC   = POLL_US * REF_MHZ;
  localparam int NPOLL      = LIMIT_US / POLL_US;
  localparam int TMR_MAX    = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);
  localparam int PC_W       = $clog2(NPOLL + 1);
  localparam int NUM        = WINDOW * REF_MHZ * SR_COEF;
  localparam int NUM_W      = $clog2(NUM + 1);

  seq_state_t         state_q;
  logic [TMR_W-1:0]   tmr_q;
  logic [PC_W-1:0]    polls_q;
  logic [COUNT_W-1:0] cnt_q;
  logic               div_start;
  logic               div_done;
  logic [NUM_W-1:0]   div_quo;
  logic [TRIM_W-1:0]  round_code;

  assign div_start = (state_q == S_FRCK_OFF) && (cnt_q != '0);

  hs_trim_divider #(.NW(NUM_W), .DW(COUNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (NUM_W'(NUM)),
    .divisor  (cnt_q),
    .done     (div_done),
    .quotient (div_quo)
  );

  hs_trim_rounder #(.NW(NUM_W), .DIVISOR(SR_DIVISOR), .TRIM_W(TRIM_W)) u_rnd (
    .quotient (div_quo),
    .code     (round_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      tmr_q        <= '0;
      polls_q      <= '0;
      cnt_q        <= '0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      osc_en_o     <= 1'b0;
      frck_en_o    <= 1'b0;
      det_en_o     <= 1'b0;
      win_cycles_o <= '0;
      trim_o       <= TRIM_W'(DEFAULT_TRIM);
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            osc_en_o <= 1'b1;
            busy_o   <= 1'b1;
            tmr_q    <= TMR_W'(SETTLE_CYC - 1);
            state_q  <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (tmr_q == '0) begin
            frck_en_o    <= 1'b1;
            win_cycles_o <= WIN_W'(WINDOW);
            state_q      <= S_ARM;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        S_ARM: begin
          det_en_o <= 1'b1;
          tmr_q    <= TMR_W'(POLL_CYC - 1);
          polls_q  <= '0;
          state_q  <= S_POLL;
        end
        S_POLL: begin
          if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
          end else if (meter_valid_i || polls_q == PC_W'(NPOLL - 1)) begin
            cnt_q    <= meter_count_i;
            det_en_o <= 1'b0;
            state_q  <= S_FRCK_OFF;
          end else begin
            polls_q <= polls_q + 1'b1;
            tmr_q   <= TMR_W'(POLL_CYC - 1);
          end
        end
        S_FRCK_OFF: begin
          frck_en_o <= 1'b0;
          if (cnt_q == '0) begin
            trim_o  <= TRIM_W'(DEFAULT_TRIM);
            state_q <= S_OSC_OFF;
          end else begin
            state_q <= S_DIV;
          end
        end
        S_DIV: begin
          if (div_done) begin
            trim_o  <= round_code;
            state_q <= S_OSC_OFF;
          end
        end
        S_OSC_OFF: begin
          osc_en_o <= 1'b0;
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_edge_trim_seq_chk.sv
module hs_edge_trim_seq_chk #(
  parameter int WINDOW = 1024,
  parameter int WIN_W  = 24,
  parameter int TRIM_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              osc_en_o,
  input logic              frck_en_o,
  input logic              det_en_o,
  input logic [WIN_W-1:0]  win_cycles_o,
  input logic [TRIM_W-1:0] trim_o
);
  p_frck_needs_osc_r1: assert property (@(posedge clk) disable iff (rst)
    frck_en_o |-> osc_en_o);

  p_det_needs_frck_r2: assert property (@(posedge clk) disable iff (rst)
    det_en_o |-> frck_en_o);

  p_frck_before_det_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(frck_en_o) |-> !det_en_o);

  p_window_loaded_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(det_en_o) |-> (win_cycles_o == WIN_W'(WINDOW)));

  p_det_off_first_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(frck_en_o) |-> (!det_en_o && $past(!det_en_o)));

  p_trim_with_osc_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(trim_o) |-> osc_en_o);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_with_osc_off_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!osc_en_o && !busy_o && $past(osc_en_o)));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind hs_edge_trim_seq hs_edge_trim_seq_chk #(
  .WINDOW (WINDOW),
  .WIN_W  (WIN_W),
  .TRIM_W (TRIM_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .osc_en_o     (osc_en_o),
  .frck_en_o    (frck_en_o),
  .det_en_o     (det_en_o),
  .win_cycles_o (win_cycles_o),
  .trim_o       (trim_o)
);

// File: tb/hs_edge_trim_seq_tb_top.sv
module hs_edge_trim_seq_tb_top;
  localparam int COUNT_W = 24;
  localparam int WIN_W   = 24;
  localparam int TRIM_W  = 3;
  localparam int NUM     = 1024 * 26 * 28;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start_i = 1'b0;
  logic               busy_o, done_o, osc_en_o, frck_en_o, det_en_o;
  logic [WIN_W-1:0]   win_cycles_o;
  logic               meter_valid_i = 1'b0;
  logic [COUNT_W-1:0] meter_count_i = '0;
  logic [TRIM_W-1:0]  trim_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  hs_edge_trim_seq dut_i (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .osc_en_o      (osc_en_o),
    .frck_en_o     (frck_en_o),
    .det_en_o      (det_en_o),
    .win_cycles_o  (win_cycles_o),
    .meter_valid_i (meter_valid_i),
    .meter_count_i (meter_count_i),
    .trim_o        (trim_o)
  );

  // meter model: valid goes high once det has been on for more than vdelay cycles
  int vdelay = 0;
  int vcount = 0;
  always @(negedge clk) begin
    if (!det_en_o) begin
      vcount = 0;
      meter_valid_i = 1'b0;
    end else begin
      vcount = vcount + 1;
      meter_valid_i = (vdelay >= 0) && (vcount > vdelay);
    end
  end

  // edge-time monitor
  int cyc = 0;
  int t_osc_r, t_osc_f, t_frck_r, t_frck_f, t_det_r, t_det_f, n_done;
  int win_at_frck, busy_at_det;
  logic p_osc = 0, p_frck = 0, p_det = 0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (osc_en_o && !p_osc) t_osc_r = cyc;
    if (!osc_en_o && p_osc) t_osc_f = cyc;
    if (frck_en_o && !p_frck) begin t_frck_r = cyc; win_at_frck = int'(win_cycles_o); end
    if (!frck_en_o && p_frck) t_frck_f = cyc;
    if (det_en_o && !p_det) begin t_det_r = cyc; busy_at_det = int'(busy_o); end
    if (!det_en_o && p_det) t_det_f = cyc;
    if (done_o) n_done = n_done + 1;
    p_osc = osc_en_o; p_frck = frck_en_o; p_det = det_en_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_trim(input int c);
    int q, t;
    if (c == 0) return 4;
    q = NUM / c;
    t = (q + 500) / 1000;
    return (t > 7) ? 7 : t;
  endfunction

  // runs one calibration; returns detector-on time
  task automatic run_one(input int c, input int dly, input bool_stray, output int det_len);
    int guard;
    vdelay = dly;
    meter_count_i = COUNT_W'(c);
    n_done = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (bool_stray) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      repeat (3) @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 8000) begin
      @(negedge clk);
      guard++;
    end
    chk(done_o == 1'b1 && trim_o == TRIM_W'(exp_trim(c)), "R6/R7 trim",
        int'(trim_o), exp_trim(c));
    @(negedge clk);
    det_len = t_det_f - t_det_r;
  endtask

  int len;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(!busy_o && !done_o && !osc_en_o && !frck_en_o && !det_en_o,
        "R1 reset idle", int'(osc_en_o), 0);
    chk(trim_o == 3'd4, "R7 reset trim", int'(trim_o), 4);

    // detailed run with an immediate valid
    run_one(2000, 0, 1'b0, len);
    chk(t_frck_r - t_osc_r == 26, "R1 settle", t_frck_r - t_osc_r, 26);
    chk(win_at_frck == 1024, "R2 window", win_at_frck, 1024);
    chk(t_det_r - t_frck_r == 1, "R2 det after frck", t_det_r - t_frck_r, 1);
    chk(busy_at_det == 1, "R1 busy", busy_at_det, 1);
    chk(len == 260, "R3 first poll", len, 260);
    chk(t_frck_f - t_det_f == 1, "R5 frck off", t_frck_f - t_det_f, 1);
    chk(t_osc_f > t_frck_f, "R5 osc off last", t_osc_f, t_frck_f + 1);
    chk(n_done == 1, "R9 done pulse", n_done, 1);
    chk(!busy_o && !osc_en_o, "R9 busy low", int'(busy_o), 0);

    // valid arriving between polls is seen at the next poll
    run_one(745, 300, 1'b0, len);
    chk(len == 520, "R3 late valid", len, 520);

    // timeouts: count read anyway
    run_one(300, 6000, 1'b0, len);
    chk(len == 5200, "R4 timeout", len, 5200);
    run_one(0, -1, 1'b0, len);
    chk(len == 5200, "R4 timeout zero", len, 5200);

    // start while busy ignored
    run_one(120, 0, 1'b1, len);
    repeat (60) @(negedge clk);
    chk(n_done == 1 && !busy_o && !osc_en_o, "R10 stray start", n_done, 1);
    // trim holds between runs
    chk(trim_o == TRIM_W'(exp_trim(120)), "R8 trim held", int'(trim_o), exp_trim(120));

    // zero count with valid
    run_one(0, 0, 1'b0, len);

    // rounding boundaries
    for (int k = 1; k <= 7; k++) begin
      int c = NUM / (1000 * k - 500);
      run_one(c, 0, 1'b0, len);
      run_one(c + 1, 0, 1'b0, len);
    end
    // sweep including saturation region
    for (int c = 1; c <= 1700; c += 13) run_one(c, 0, 1'b0, len);
    for (int c = 0; c < 8; c++) run_one(20000 * c + 3, 0, 1'b0, len);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule